// File: doc/BRIEF.md
# Indexed GPIO Port Controller

This block gives a host twenty general-purpose pins, split into two 8-bit ports (A and B) and one 4-bit port (C). The host sees only two byte-wide I/O addresses. One holds an index pointer. The other is a data window that reaches whichever internal register the pointer selects. Every register access is therefore a two-step sequence: first write the index, then read or write the window.

Each port has two registers. The direction register decides, bit by bit, whether a pin is driven. The value register holds the output latch, and reading it returns the pins' state. On the pin side the block presents separate output, output-enable and input vectors. Input pins pass through a two-stage synchronizer before they can be read.

Top module: `gpio_idx_ctrl`

## Requirements
- R1: A write to address 22h loads the index pointer. The pointer keeps its value until 22h is written again, and a read of 22h returns it.
- R2: A write to address 23h updates the register that the current index selects. Index A5h/A4h/A3h is the direction register of port A/B/C, and A9h/A8h/A7h is the value register of port A/B/C. Reading 23h at a mapped index returns that register.
- R3: Each direction bit drives the output-enable of its pin, with 1 meaning output. Pin bits 7:0 belong to port A, 15:8 to port B and 19:16 to port C. The output-enables change only on a write through the window.
- R4: The value-register latch drives the pin output vector at all times, and a write updates it whatever the direction bits are. A latch bit whose direction bit is 0 does not enable its pin.
- R5: A value-register read returns the latch bit for output bits and the synchronized pin level for input bits.
- R6: A change on an input pin shows up in the value-register readback after two rising clock edges.
- R7: While reset is high, the index, every direction register and every latch clear to zero, so all pins are inputs and the outputs are low.
- R8: Bits 7:4 of port C's direction and value registers ignore writes and read as zero.
- R9: A window read at an unmapped index returns FFh. A window write at an unmapped index changes no register.
- R10: The read data bus is 00h whenever the read strobe is low. A read of any address other than 22h or 23h also returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | I/O address of the host access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pin_in | input | 20 | Pin levels as sensed (A 7:0, B 15:8, C 19:16) |
| pin_out | output | 20 | Output latch values per pin |
| pin_oe | output | 20 | Output enable per pin |

## Verification
The assertions check on every cycle that the read bus is idle when no read is in progress, and that the output vectors change only after a window write. They also check that reset clears the pins and that an index written to 22h reads back on the next cycle. The index-to-register mapping, the mixed latch/pin readback, the two-edge synchronizer latency, the masking of port C's upper bits and the inertness of unmapped indices depend on sequences of accesses. Only the bench's scenarios, compared each cycle against its reference model, can show those.

// File: rtl/gpio_idx_pkg.sv
package gpio_idx_pkg;

    localparam int BUS_W    = 8;
    localparam int NPORTS   = 3;
    localparam int PIN_W    = 20;
    localparam logic [BUS_W-1:0] ADDR_INDEX  = 8'h22;
    localparam logic [BUS_W-1:0] ADDR_WINDOW = 8'h23;
    localparam logic [BUS_W-1:0] DIR_BASE    = 8'hA5;
    localparam logic [BUS_W-1:0] VAL_BASE    = 8'hA9;
    localparam logic [BUS_W-1:0] UNMAPPED_RD = 8'hFF;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_DIR  = 2'd1,
        REG_VAL  = 2'd2
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] port;
    } idx_dec_t;

    function automatic int port_width(input int p);
        return (p == 2) ? 4 : 8;
    endfunction

    function automatic int port_offset(input int p);
        int acc;
        acc = 0;
        for (int i = 0; i < p; i++) acc += port_width(i);
        return acc;
    endfunction

    function automatic logic [BUS_W-1:0] dir_index(input int p);
        return DIR_BASE - BUS_W'(p);
    endfunction

    function automatic logic [BUS_W-1:0] val_index(input int p);
        return VAL_BASE - BUS_W'(p);
    endfunction

    function automatic idx_dec_t decode_index(input logic [BUS_W-1:0] idx);
        idx_dec_t d;
        d.kind = REG_NONE;
        d.port = 2'd0;
        for (int p = 0; p < NPORTS; p++) begin
            if (idx == dir_index(p)) begin
                d.kind = REG_DIR;
                d.port = 2'(p);
            end
            if (idx == val_index(p)) begin
                d.kind = REG_VAL;
                d.port = 2'(p);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_port_reg.sv
module gpio_port_reg #(
    parameter int W     = 8,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_we,
    input  logic             val_we,
    input  logic [BUS_W-1:0] wdata,
    output logic [W-1:0]     dir_q,
    output logic [W-1:0]     lat_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            lat_q <= '0;
        end else begin
            if (dir_we) dir_q <= wdata[W-1:0];
            if (val_we) lat_q <= wdata[W-1:0];
        end
    end
endmodule

// File: rtl/gpio_idx_ctrl.sv
module gpio_idx_ctrl
    import gpio_idx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_oe
);
    logic [BUS_W-1:0] idx_q;
    logic [PIN_W-1:0] pin_sync;
    idx_dec_t         sel;
    logic             win_wr;
    logic [NPORTS-1:0][BUS_W-1:0] dir_rd;
    logic [NPORTS-1:0][BUS_W-1:0] val_rd;
    logic [BUS_W-1:0] rd_val;

    always_ff @(posedge clk) begin
        if (rst)                                  idx_q <= '0;
        else if (bus_wr && bus_addr == ADDR_INDEX) idx_q <= bus_wdata;
    end

    assign sel    = decode_index(idx_q);
    assign win_wr = bus_wr && (bus_addr == ADDR_WINDOW);

    gpio_in_sync #(.W(PIN_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam int PW  = port_width(p);
        localparam int OFF = port_offset(p);
        logic [PW-1:0] dir_q;
        logic [PW-1:0] lat_q;
        logic [PW-1:0] seen;

        gpio_port_reg #(.W(PW), .BUS_W(BUS_W)) u_reg (
            .clk    (clk),
            .rst    (rst),
            .dir_we (win_wr && sel.kind == REG_DIR && sel.port == 2'(p)),
            .val_we (win_wr && sel.kind == REG_VAL && sel.port == 2'(p)),
            .wdata  (bus_wdata),
            .dir_q  (dir_q),
            .lat_q  (lat_q)
        );

        assign seen            = (dir_q & lat_q) | (~dir_q & pin_sync[OFF +: PW]);
        assign dir_rd[p]       = BUS_W'(dir_q);
        assign val_rd[p]       = BUS_W'(seen);
        assign pin_oe[OFF +: PW]  = dir_q;
        assign pin_out[OFF +: PW] = lat_q;
    end

    always_comb begin
        rd_val = '0;
        if (bus_addr == ADDR_INDEX) begin
            rd_val = idx_q;
        end else if (bus_addr == ADDR_WINDOW) begin
            unique case (sel.kind)
                REG_DIR: rd_val = dir_rd[sel.port];
                REG_VAL: rd_val = val_rd[sel.port];
                default: rd_val = UNMAPPED_RD;
            endcase
        end
    end

    assign bus_rdata = bus_rd ? rd_val : '0;

endmodule

// File: rtl/gpio_idx_ctrl_chk.sv
module gpio_idx_ctrl_chk
    import gpio_idx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [BUS_W-1:0] bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [BUS_W-1:0] bus_wdata,
    input logic [BUS_W-1:0] bus_rdata,
    input logic [PIN_W-1:0] pin_out,
    input logic [PIN_W-1:0] pin_oe
);
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> bus_rdata == '0); // R10

    AST_RESET_PINS_CLEAR: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0)); // R7

    AST_OE_ONLY_ON_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == ADDR_WINDOW) |=> $stable(pin_oe)); // R3

    AST_OUT_ONLY_ON_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == ADDR_WINDOW) |=> $stable(pin_out)); // R4

    AST_INDEX_READBACK: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_INDEX) |=>
            ((bus_rd && bus_addr == ADDR_INDEX) -> bus_rdata == $past(bus_wdata))); // R1
endmodule

bind gpio_idx_ctrl gpio_idx_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/sim_gpio_idx_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_idx_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [19:0] pin_in = 20'h0;
    logic [19:0] pin_out;
    logic [19:0] pin_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_idx_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // behavioural reference model
    bit [7:0]  m_idx;
    bit [7:0]  m_dir [3];
    bit [7:0]  m_lat [3];
    bit [19:0] m_s1, m_s2;

    function automatic int map_port(input bit [7:0] idx, output bit is_val);
        is_val = 0;
        case (idx)
            8'hA5: return 0;
            8'hA4: return 1;
            8'hA3: return 2;
            8'hA9: begin is_val = 1; return 0; end
            8'hA8: begin is_val = 1; return 1; end
            8'hA7: begin is_val = 1; return 2; end
            default: return -1;
        endcase
    endfunction

    function automatic bit [7:0] sync_slice(input int p);
        if (p == 0) return m_s2[7:0];
        if (p == 1) return m_s2[15:8];
        return {4'h0, m_s2[19:16]};
    endfunction

    function automatic bit [7:0] model_rd();
        bit iv;
        int p;
        if (!bus_rd) return 8'h00;
        if (bus_addr == 8'h22) return m_idx;
        if (bus_addr != 8'h23) return 8'h00;
        p = map_port(m_idx, iv);
        if (p < 0) return 8'hFF;
        if (!iv) return m_dir[p];
        return (m_dir[p] & m_lat[p]) | (~m_dir[p] & sync_slice(p));
    endfunction

    function automatic string rd_tag();
        bit iv;
        if (!bus_rd || (bus_addr != 8'h22 && bus_addr != 8'h23)) return "R10";
        if (bus_addr == 8'h22) return "R1";
        if (map_port(m_idx, iv) < 0) return "R9";
        if (m_idx == 8'hA3 || m_idx == 8'hA7) return "R8";
        return iv ? "R5" : "R2";
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_idx = 0; m_s1 = 0; m_s2 = 0;
            for (int i = 0; i < 3; i++) begin m_dir[i] = 0; m_lat[i] = 0; end
        end else begin
            bit iv;
            int p;
            m_s2 = m_s1;
            m_s1 = pin_in;
            if (bus_wr && bus_addr == 8'h23) begin
                p = map_port(m_idx, iv);
                if (p >= 0) begin
                    if (iv) m_lat[p] = bus_wdata & ((p == 2) ? 8'h0F : 8'hFF);
                    else    m_dir[p] = bus_wdata & ((p == 2) ? 8'h0F : 8'hFF);
                end
            end
            if (bus_wr && bus_addr == 8'h22) m_idx = bus_wdata;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            check("R3", pin_oe,  {m_dir[2][3:0], m_dir[1], m_dir[0]});
            check("R4", pin_out, {m_lat[2][3:0], m_lat[1], m_lat[0]});
            check(rd_tag(), bus_rdata, model_rd());
        end
    end

    task automatic wr(input bit [7:0] a, input bit [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic set_reg(input bit [7:0] idx, input bit [7:0] d);
        wr(8'h22, idx);
        wr(8'h23, d);
    endtask

    task automatic rd_chk(input bit [7:0] a, input bit [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #1 check(req, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        #1 check("R7", pin_oe, 20'h0);
        check("R7", pin_out, 20'h0);
        @(negedge clk) rst = 0;
        rd_chk(8'h22, 8'h00, "R7");
        rd_chk(8'h23, 8'hFF, "R9");

        // R2/R3/R4: direction and latch programming
        set_reg(8'hA5, 8'hFF);
        set_reg(8'hA4, 8'h00);
        set_reg(8'hA9, 8'h5A);
        #1 check("R3", pin_oe[7:0], 8'hFF);
        check("R4", pin_out[7:0], 8'h5A);
        rd_chk(8'h23, 8'h5A, "R5");
        // R1: index holds across repeated window reads
        rd_chk(8'h23, 8'h5A, "R1");
        rd_chk(8'h22, 8'hA9, "R1");

        // R4: latch written on input port, pin not enabled
        set_reg(8'hA8, 8'h3C);
        #1 check("R4", pin_out[15:8], 8'h3C);
        check("R4", pin_oe[15:8], 8'h00);

        // R6: two-edge synchronizer latency on port B
        pin_in[15:8] = 8'h00;
        repeat (3) @(negedge clk);
        bus_addr = 8'h23; bus_rd = 1; pin_in[15:8] = 8'hC3;
        #1 check("R6", bus_rdata, 8'h00);
        @(negedge clk); #1 check("R6", bus_rdata, 8'h00);
        @(negedge clk); #1 check("R6", bus_rdata, 8'hC3);
        @(negedge clk) bus_rd = 0;

        // R5: mixed direction on port A
        pin_in[7:0] = 8'hF0;
        set_reg(8'hA5, 8'h0F);
        wr(8'h22, 8'hA9);
        rd_chk(8'h23, 8'hFA, "R5");

        // R8: port C upper bits
        set_reg(8'hA3, 8'hFF);
        #1 check("R8", pin_oe[19:16], 4'hF);
        rd_chk(8'h23, 8'h0F, "R8");
        pin_in[19:16] = 4'h9;
        set_reg(8'hA7, 8'hA6);
        rd_chk(8'h23, 8'h06, "R8");
        set_reg(8'hA3, 8'h00);
        repeat (2) @(negedge clk);
        wr(8'h22, 8'hA7);
        rd_chk(8'h23, 8'h09, "R8");

        // R9: unmapped index
        set_reg(8'hA6, 8'h77);
        rd_chk(8'h23, 8'hFF, "R9");
        #1 check("R9", pin_out, {4'h6, 8'h3C, 8'h5A});
        check("R9", pin_oe, {4'h0, 8'h00, 8'h0F});

        // R10: other addresses and idle strobe
        rd_chk(8'h40, 8'h00, "R10");
        @(negedge clk) bus_addr = 8'h22;
        #1 check("R10", bus_rdata, 8'h00);

        // R2: redirect by rewriting index between accesses
        wr(8'h22, 8'hA9);
        wr(8'h22, 8'hA4);
        wr(8'h23, 8'h81);
        #1 check("R2", pin_oe[15:8], 8'h81);
        check("R2", pin_out[7:0], 8'h5A);

        // R7: reset mid-run clears everything
        @(negedge clk) rst = 1;
        @(negedge clk); #1 check("R7", {pin_oe, pin_out}, 40'h0);
        @(negedge clk) rst = 0;
        rd_chk(8'h22, 8'h00, "R7");

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule